// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Timer

This block watches the receive side of a serial port and signals that words are sitting in the receive FIFO with no new ones arriving. It counts bus clock cycles while the port is enabled and the FIFO holds at least one word. Each word pushed into the FIFO sends the count back to zero. When the count reaches a programmed 24-bit limit, a sticky timeout flag is raised. Software or a DMA engine can then collect trailing words that never reach the FIFO service threshold.

The flag stays set until a status write with a one in the flag position clears it. After an expiry the counter stops until the next word arrives, so one idle stretch raises the flag once. A trailing-data steering input decides who is told about the residue: the processor interrupt request or the DMA request line. The FIFO storage and the interrupt masking sit outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flag, both request outputs and the internal count return to zero. All three outputs read 0 after reset.
- R2: A limit of zero disables the timer, and the flag never sets however long the FIFO stays idle.
- R3: A cycle with `rx_push` high restarts the count at zero and is not counted. With limit L>0, the flag reads 1 after L consecutive counted cycles following the push, and reads 0 after L-1.
- R4: The count is held at zero in any cycle where `port_en` or `rx_nonempty` is low. Counting begins again from zero once both are high.
- R5: The flag is sticky. A cycle with `flag_wr`=1 and `flag_wdata`=1 clears it. A write with `flag_wdata`=0 leaves it set.
- R6: After an expiry the counter stops. Clearing the flag does not make it set again while the FIFO stays idle; only a new `rx_push` re-arms the timer.
- R7: If an expiry and a clearing write fall in the same cycle, the flag ends set.
- R8: Expiry is detected when the next count value is greater than or equal to the limit. Lowering the limit below the elapsed count makes the flag set at the next edge.
- R9: `tmo_irq` equals the flag when `trail_dma`=0 and is 0 otherwise. `tmo_dma` equals the flag when `trail_dma`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| tmo_limit | input | CNT_W (24) | Idle limit in bus clock cycles, 0 disables |
| rx_push | input | 1 | One-cycle strobe: a word was written into the receive FIFO |
| rx_nonempty | input | 1 | Receive FIFO holds at least one word |
| trail_dma | input | 1 | Route trailing-data notice to DMA (1) or interrupt (0) |
| flag_wr | input | 1 | Status write strobe |
| flag_wdata | input | 1 | Status write data for the flag bit (1 clears) |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout notice toward the processor interrupt path |
| tmo_dma | output | 1 | Timeout notice toward the DMA request path |

## Verification
The bench measures the exact edge at which the flag rises at limits of 1, small, and 255. An off-by-one counter would show the flag one cycle early or late, and a design that counted the push cycle would fire early. It re-pushes mid-count, drains the FIFO, and drops the port enable. A timer that did not restart or hold on these events would expire too soon. Four further cases are each caught by a distinct wrong result:
- A clear followed by a long idle stretch, which catches a counter that keeps running after expiry and flags a second time.
- A clear that lands on the expiry edge, which exposes a design that loses the event.
- A limit lowered below the elapsed count, which exposes an equality compare that never fires.
- Both settings of the steering bit, which exposes swapped request outputs.

// File: rtl/rx_idle_timeout_pkg.sv
// Shared widths and types for the receive idle timeout timer.
package rx_idle_timeout_pkg;
    // Width of the programmable idle limit and of the idle counter.
    localparam int TMO_CNT_W = 24;
endpackage

// File: rtl/rxto_idle_counter.sv
// Idle counter. Counts bus cycles while the receive FIFO holds data and
// the port is enabled. An arrival strobe restarts it at zero. It reports
// a one-cycle hit when the next count reaches the limit, then parks until
// the next arrival.
// Assumes: arrive is a single-cycle strobe per pushed word.
module rxto_idle_counter #(
    parameter int CNT_W = rx_idle_timeout_pkg::TMO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] limit,
    input  logic             arrive,
    output logic             hit
);
    localparam int NXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             parked_q;
    logic [NXT_W-1:0] cnt_next;
    logic             limit_zero;
    logic             counting;

    // Decide whether this cycle counts and whether it reaches the limit.
    always_comb begin
        cnt_next   = {1'b0, cnt_q} + NXT_W'(1);
        limit_zero = (limit == '0);
        counting   = run_ok && !limit_zero && !parked_q && !arrive;
        hit        = counting && (cnt_next >= {1'b0, limit});
    end

    // Advance, restart, hold or park the idle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            parked_q <= 1'b0;
        end else if (arrive || !run_ok || limit_zero) begin
            cnt_q    <= '0;
            parked_q <= 1'b0;
        end else if (hit) begin
            cnt_q    <= '0;
            parked_q <= 1'b1;
        end else if (counting) begin
            cnt_q    <= cnt_next[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/rxto_sticky_flag.sv
// Sticky status bit with write-one-to-clear. A set request in the same
// cycle as a clearing write wins, so no event is lost.
// Assumes: wr and wdata come from one status register write.
module rxto_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic flag
);
    logic clr;

    // A clear needs the write strobe and a one in the flag position.
    always_comb clr = wr && wdata;

    // Hold the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/rxto_route.sv
// Steers the timeout notice to the processor interrupt path or the DMA
// request path, chosen by the trailing-data steering bit.
// Assumes: the steering bit is static while the flag is set.
module rxto_route (
    input  logic flag,
    input  logic to_dma,
    output logic irq_req,
    output logic dma_req
);
    // Exactly one path sees the flag.
    always_comb begin
        irq_req = flag && !to_dma;
        dma_req = flag &&  to_dma;
    end
endmodule

// File: rtl/rx_idle_timeout.sv
// Receive FIFO idle timeout timer: counter, sticky flag and request steering.
// Assumes: all inputs are synchronous to clk. rx_push pulses once per word.
module rx_idle_timeout #(
    parameter int CNT_W = rx_idle_timeout_pkg::TMO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [CNT_W-1:0] tmo_limit,
    input  logic             rx_push,
    input  logic             rx_nonempty,
    input  logic             trail_dma,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             tmo_flag,
    output logic             tmo_irq,
    output logic             tmo_dma
);
    logic run_ok;
    logic hit;

    // The timer runs only with the port enabled and data waiting.
    always_comb run_ok = port_en && rx_nonempty;

    rxto_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_ok (run_ok),
        .limit  (tmo_limit),
        .arrive (rx_push),
        .hit    (hit)
    );

    rxto_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .wr    (flag_wr),
        .wdata (flag_wdata),
        .flag  (tmo_flag)
    );

    rxto_route u_route (
        .flag    (tmo_flag),
        .to_dma  (trail_dma),
        .irq_req (tmo_irq),
        .dma_req (tmo_dma)
    );
endmodule

// File: rtl/rx_idle_timeout_chk.sv
// Property checker for the idle timeout timer, attached by bind.
module rx_idle_timeout_chk #(
    parameter int CNT_W = rx_idle_timeout_pkg::TMO_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic [CNT_W-1:0] tmo_limit,
    input logic             rx_push,
    input logic             rx_nonempty,
    input logic             trail_dma,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic             tmo_flag,
    input logic             tmo_irq,
    input logic             tmo_dma
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !tmo_flag);

    a_r2_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_limit == '0 && !tmo_flag) |=> !tmo_flag);

    a_r3_push_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !tmo_flag) |=> !tmo_flag);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((!port_en || !rx_nonempty) && !tmo_flag) |=> !tmo_flag);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !(flag_wr && flag_wdata)) |=> tmo_flag);

    a_r9_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmo_irq, tmo_dma}) && ((tmo_irq || tmo_dma) == tmo_flag));

    a_r9_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && trail_dma) |-> tmo_dma);
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .tmo_limit   (tmo_limit),
    .rx_push     (rx_push),
    .rx_nonempty (rx_nonempty),
    .trail_dma   (trail_dma),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .tmo_flag    (tmo_flag),
    .tmo_irq     (tmo_irq),
    .tmo_dma     (tmo_dma)
);

// File: tb/rx_idle_timeout_tb_top.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module rx_idle_timeout_tb_top;
    localparam int CNT_W = 24;

    typedef struct packed {
        logic [23:0] lim;
        logic [15:0] idle;
        logic        trail;
        logic        exp_flag;
    } vec_t;

    // Each entry: limit, idle cycles after one push, steering, expected flag (R3, R2, R9).
    localparam vec_t VECS [12] = '{
        '{24'd5,   16'd4,   1'b0, 1'b0},
        '{24'd5,   16'd5,   1'b0, 1'b1},
        '{24'd1,   16'd0,   1'b0, 1'b0},
        '{24'd1,   16'd1,   1'b1, 1'b1},
        '{24'd0,   16'd60,  1'b0, 1'b0},
        '{24'd0,   16'd3,   1'b1, 1'b0},
        '{24'd3,   16'd12,  1'b1, 1'b1},
        '{24'd255, 16'd254, 1'b0, 1'b0},
        '{24'd255, 16'd255, 1'b1, 1'b1},
        '{24'd2,   16'd1,   1'b1, 1'b0},
        '{24'd16,  16'd16,  1'b0, 1'b1},
        '{24'd16,  16'd15,  1'b1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             port_en = 1'b1;
    logic [CNT_W-1:0] tmo_limit = '0;
    logic             rx_push = 1'b0;
    logic             rx_nonempty = 1'b0;
    logic             trail_dma = 1'b0;
    logic             flag_wr = 1'b0;
    logic             flag_wdata = 1'b0;
    logic             tmo_flag;
    logic             tmo_irq;
    logic             tmo_dma;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_idle_timeout #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .tmo_limit(tmo_limit),
        .rx_push(rx_push), .rx_nonempty(rx_nonempty), .trail_dma(trail_dma),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .tmo_flag(tmo_flag), .tmo_irq(tmo_irq), .tmo_dma(tmo_dma)
    );

    // Compare {flag, irq, dma} with the value derived from the requirements.
    task automatic check(input string req, input logic exp_flag, input logic steer);
        logic [2:0] act;
        logic [2:0] exp;
        act = {tmo_flag, tmo_irq, tmo_dma};
        exp = {exp_flag, exp_flag && !steer, exp_flag && steer};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {flag,irq,dma} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Drain the FIFO view and clear the flag for one cycle.
    task automatic quiesce();
        rx_nonempty = 1'b0;
        flag_wr = 1'b1;
        flag_wdata = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0;
        flag_wdata = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3 and R9.
        for (int i = 0; i < 12; i++) begin
            quiesce();
            tmo_limit   = VECS[i].lim;
            trail_dma   = VECS[i].trail;
            rx_nonempty = 1'b1;
            push();
            idle(int'(VECS[i].idle));
            check($sformatf("R3/R2/R9 vector %0d", i), VECS[i].exp_flag, VECS[i].trail);
        end
        trail_dma = 1'b0;

        // R3: a push mid-count restarts it.
        quiesce(); tmo_limit = 24'd6; rx_nonempty = 1'b1; push();
        idle(5); check("R3 before re-arm", 1'b0, 1'b0);
        push(); idle(5); check("R3 after re-arm", 1'b0, 1'b0);
        idle(1); check("R3 expiry after re-arm", 1'b1, 1'b0);

        // R4: an empty FIFO holds the count at zero.
        quiesce(); tmo_limit = 24'd4; rx_nonempty = 1'b1; push();
        idle(2); rx_nonempty = 1'b0; idle(3); rx_nonempty = 1'b1;
        idle(3); check("R4 empty restarts count", 1'b0, 1'b0);
        idle(1); check("R4 expiry after refill", 1'b1, 1'b0);

        // R4: a disabled port holds the count at zero.
        quiesce(); port_en = 1'b0; tmo_limit = 24'd2; rx_nonempty = 1'b1; push();
        idle(20); check("R4 port disabled", 1'b0, 1'b0);
        port_en = 1'b1; idle(1); check("R4 one cycle after enable", 1'b0, 1'b0);
        idle(1); check("R4 expiry after enable", 1'b1, 1'b0);

        // R5: a write of zero keeps the flag, a write of one clears it.
        flag_wr = 1'b1; flag_wdata = 1'b0; @(negedge clk); flag_wr = 1'b0;
        check("R5 write zero keeps flag", 1'b1, 1'b0);
        idle(4); check("R5 flag sticky", 1'b1, 1'b0);
        flag_wr = 1'b1; flag_wdata = 1'b1; @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R5 write one clears", 1'b0, 1'b0);

        // R6: after expiry only a new arrival re-arms.
        idle(12); check("R6 parked after clear", 1'b0, 1'b0);
        push(); idle(1); check("R6 re-armed, not yet", 1'b0, 1'b0);
        idle(1); check("R6 expiry after new arrival", 1'b1, 1'b0);

        // R7: expiry and clear in the same cycle leave the flag set.
        quiesce(); tmo_limit = 24'd3; rx_nonempty = 1'b1; push(); idle(2);
        flag_wr = 1'b1; flag_wdata = 1'b1; @(negedge clk);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R7 set wins over clear", 1'b1, 1'b0);

        // R8: lowering the limit below the elapsed count fires next edge.
        quiesce(); tmo_limit = 24'd100; rx_nonempty = 1'b1; push();
        idle(10); check("R8 large limit pending", 1'b0, 1'b0);
        tmo_limit = 24'd4; idle(1); check("R8 lowered limit fires", 1'b1, 1'b0);

        // R1: reset during operation clears the flag.
        rst_n = 1'b0; @(negedge clk); check("R1 mid-run reset", 1'b0, 1'b0);
        rst_n = 1'b1; rx_nonempty = 1'b0;
        @(negedge clk);

        finish_run();
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule